// File: doc/BRIEF.md
# Flag-Setting 16-Bit Execute ALU

This block is the execute stage for the two-operand and one-operand instruction groups of a small 16-bit processor. Operand fetch and writeback logic present it with a decoded instruction: a group select, the opcode field of that group, a byte/word select, a source value, a destination value and the current status flags. One clock later the block returns the result, a write-enable that says whether the destination should be updated, and the new status flags.

Each operation has its own flag policy. Arithmetic operations derive carry and signed overflow from the adder. Logical operations set carry to "result is nonzero". The bit-set, bit-clear and move operations pass the incoming flags through unchanged. Compare and bit-test produce flags only. In byte mode the operation uses the low 8 bits, the flags are taken at bit 7, and the upper byte of the result is zero. Decimal add and the stack and control opcodes are not handled here. They come out as no-ops: nothing is written and the flags are unchanged.

Top module: `alu16_exec`

## Requirements
- R1: Every accepted request (`in_valid`=1) yields `out_valid`=1 with its result exactly one clock later. `out_valid` is 0 in the cycle after an idle cycle, and `out_wr` is never 1 while `out_valid` is 0.
- R2: ADD (group 0, code 5) returns dst+src. C is the carry out of the operand MSB. V is set when both addends share a sign and the result sign differs. N is the result MSB and Z means the result is zero. Flags use bit 0 C, bit 1 Z, bit 2 N, bit 3 V.
- R3: ADDC (code 6) returns dst+src+C_in. Its flags follow R2.
- R4: SUB (code 8) returns dst+~src+1 and SUBC (code 7) returns dst+~src+C_in. C is the carry out, so C=1 means no borrow. V follows R2 with ~src as the second addend.
- R5: CMP (code 9) and BIT (code 11) update the flags and leave `out_wr`=0. CMP flags follow SUB.
- R6: AND (15), BIT (11) and XOR (14) set N from the result MSB, Z on a zero result and C on a nonzero result. V is 0, except that XOR sets V when both operands are negative.
- R7: MOV (4) returns src, BIC (12) returns dst&~src and BIS (13) returns dst|src. All three write, and `out_flags` equals the incoming flags.
- R8: With `in_byte`=1, two-operand operations and the two right shifts act on bits 7:0. Flags are taken at bit 7 and bit 8 of the sum, and result bits 15:8 are zero.
- R9: RRC (group 1, code 0) shifts right by one, moves the incoming C into the MSB and the old LSB into C. N and Z come from the result and V is cleared.
- R10: RRA (group 1, code 2) shifts right arithmetically, keeping the MSB, with the old LSB going to C. N and Z come from the result and V is cleared.
- R11: SWPB (group 1, code 1) exchanges the two bytes of the operand, ignores `in_byte` and leaves the flags unchanged.
- R12: SXT (group 1, code 3) copies bit 7 into bits 15:8 and ignores `in_byte`. It sets N and Z from the result, C when the result is nonzero, and clears V.
- R13: Decimal add (group 0, code 10), two-operand codes 0 to 3 and one-operand codes 4 to 7 write nothing and leave the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| in_group | input | 1 | 0 = two-operand group, 1 = one-operand group |
| in_op2 | input | 4 | Two-operand opcode (instruction bits 15:12) |
| in_op1 | input | 3 | One-operand opcode (instruction bits 9:7) |
| in_byte | input | 1 | 1 = byte operation |
| in_src | input | 16 | Source operand (two-operand group) |
| in_dst | input | 16 | Destination operand, or the sole operand of the one-operand group |
| in_flags | input | 4 | Incoming flags {V,N,Z,C} |
| out_valid | output | 1 | Result present this cycle |
| out_result | output | 16 | Operation result |
| out_wr | output | 1 | Destination must be written with out_result |
| out_flags | output | 4 | Updated flags {V,N,Z,C} |

## Verification
A wrong carry-in selection or a wrong sign tap shows up in the very next cycle as a wrong C or V on `out_flags`, often with a correct `out_result`. For that reason the flags are compared on every request, including requests that write nothing. A byte-mode masking error appears as nonzero upper bits or a wrong N/C. A decode slip between the flag-preserving operations and the flag-setting ones shows up as flags that differ from `in_flags` after MOV, BIC, BIS or SWPB. Because the block holds only one stage of state, every fault is visible one cycle after the request that triggers it.

// File: rtl/alu16_pkg.sv
`timescale 1ns/1ps
// Package: opcode encodings and the flag word layout shared by the ALU.
// Assumes the flag word is packed as {V,N,Z,C} with C in bit 0.
package alu16_pkg;

    typedef enum logic [3:0] {
        D_MOV  = 4'd4,
        D_ADD  = 4'd5,
        D_ADDC = 4'd6,
        D_SUBC = 4'd7,
        D_SUB  = 4'd8,
        D_CMP  = 4'd9,
        D_DADD = 4'd10,
        D_BIT  = 4'd11,
        D_BIC  = 4'd12,
        D_BIS  = 4'd13,
        D_XOR  = 4'd14,
        D_AND  = 4'd15
    } dual_op_e;

    typedef enum logic [2:0] {
        S_RRC  = 3'd0,
        S_SWPB = 3'd1,
        S_RRA  = 3'd2,
        S_SXT  = 3'd3
    } single_op_e;

    typedef struct packed {
        logic v;
        logic n;
        logic z;
        logic c;
    } flags_t;

endpackage

// File: rtl/alu16_flag_eval.sv
`timescale 1ns/1ps
// Module: alu16_flag_eval
// Derives the zero and negative flags from a result at word or byte width.
// Assumes that in byte mode only bits HALF_W-1:0 carry meaning.
module alu16_flag_eval #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] val,
    input  logic              byte_mode,
    output logic              zero,
    output logic              neg
);
    localparam int HALF_W = DATA_W / 2;

    // Select the width at which zero and sign are judged.
    always_comb begin
        if (byte_mode) begin
            zero = (val[HALF_W-1:0] == '0);
            neg  = val[HALF_W-1];
        end else begin
            zero = (val == '0);
            neg  = val[DATA_W-1];
        end
    end
endmodule

// File: rtl/alu16_dual.sv
`timescale 1ns/1ps
// Module: alu16_dual
// Combinational datapath for the two-operand group: add/subtract family,
// logic operations and moves, with a per-operation flag policy.
// Assumes a byte operation ignores the upper half of both operands.
module alu16_dual
    import alu16_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [3:0]        op,
    input  logic              byte_mode,
    input  logic [DATA_W-1:0] src,
    input  logic [DATA_W-1:0] dst,
    input  flags_t            flags_in,
    output logic [DATA_W-1:0] res,
    output logic              wr,
    output flags_t            flags_out
);
    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] mask, a_v, s_v, ns_v, add_b;
    logic              add_ci;
    logic [DATA_W:0]   sum;
    logic              carry, ovf, sa, sb, sr;
    logic              z_w, n_w;

    typedef enum logic [1:0] {FL_KEEP, FL_ARITH, FL_LOGIC, FL_XOR} fl_kind_e;
    fl_kind_e kind;

    // Mask the operands to the active width and pick the adder inputs.
    always_comb begin
        mask = byte_mode ? {{(DATA_W-HALF_W){1'b0}}, {HALF_W{1'b1}}} : {DATA_W{1'b1}};
        a_v  = dst & mask;
        s_v  = src & mask;
        ns_v = ~src & mask;
        unique case (dual_op_e'(op))
            D_ADD:         begin add_b = s_v;  add_ci = 1'b0;       end
            D_ADDC:        begin add_b = s_v;  add_ci = flags_in.c; end
            D_SUBC:        begin add_b = ns_v; add_ci = flags_in.c; end
            D_SUB, D_CMP:  begin add_b = ns_v; add_ci = 1'b1;       end
            default:       begin add_b = s_v;  add_ci = 1'b0;       end
        endcase
        sum   = {1'b0, a_v} + {1'b0, add_b} + {{DATA_W{1'b0}}, add_ci};
        carry = byte_mode ? sum[HALF_W] : sum[DATA_W];
    end

    // Choose the result, the write-enable and the flag policy per opcode.
    always_comb begin
        res  = '0;
        wr   = 1'b0;
        kind = FL_KEEP;
        unique case (dual_op_e'(op))
            D_MOV:                 begin res = s_v;              wr = 1'b1; end
            D_ADD, D_ADDC,
            D_SUBC, D_SUB:         begin res = sum[DATA_W-1:0] & mask; wr = 1'b1; kind = FL_ARITH; end
            D_CMP:                 begin res = sum[DATA_W-1:0] & mask; kind = FL_ARITH; end
            D_BIT:                 begin res = a_v & s_v;        kind = FL_LOGIC; end
            D_AND:                 begin res = a_v & s_v;        wr = 1'b1; kind = FL_LOGIC; end
            D_XOR:                 begin res = a_v ^ s_v;        wr = 1'b1; kind = FL_XOR; end
            D_BIC:                 begin res = a_v & ns_v;       wr = 1'b1; end
            D_BIS:                 begin res = a_v | s_v;        wr = 1'b1; end
            default:               begin res = '0; end
        endcase
    end

    alu16_flag_eval #(.DATA_W(DATA_W)) u_feval (
        .val       (res),
        .byte_mode (byte_mode),
        .zero      (z_w),
        .neg       (n_w)
    );

    // Assemble the outgoing flags from the chosen policy.
    always_comb begin
        sa  = byte_mode ? a_v[HALF_W-1]   : a_v[DATA_W-1];
        sb  = byte_mode ? add_b[HALF_W-1] : add_b[DATA_W-1];
        sr  = n_w;
        ovf = (sa == sb) && (sr != sa);
        unique case (kind)
            FL_ARITH: flags_out = '{v: ovf, n: n_w, z: z_w, c: carry};
            FL_LOGIC: flags_out = '{v: 1'b0, n: n_w, z: z_w, c: !z_w};
            FL_XOR:   flags_out = '{v: sa && (byte_mode ? s_v[HALF_W-1] : s_v[DATA_W-1]),
                                    n: n_w, z: z_w, c: !z_w};
            default:  flags_out = flags_in;
        endcase
    end
endmodule

// File: rtl/alu16_single.sv
`timescale 1ns/1ps
// Module: alu16_single
// Combinational datapath for the one-operand group: rotate through carry,
// arithmetic shift, byte swap and sign extension.
// Assumes swap and sign extension are word operations whatever byte_mode says.
module alu16_single
    import alu16_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [2:0]        op,
    input  logic              byte_mode,
    input  logic [DATA_W-1:0] opnd,
    input  flags_t            flags_in,
    output logic [DATA_W-1:0] res,
    output logic              wr,
    output flags_t            flags_out
);
    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] a_v, shr;
    logic              top_in, eff_byte, z_w, n_w;

    // Form the shifted value with the requested fill bit at the active MSB.
    always_comb begin
        a_v = byte_mode ? {{(DATA_W-HALF_W){1'b0}}, opnd[HALF_W-1:0]} : opnd;
        if (dual_fill_is_carry(op))
            top_in = flags_in.c;
        else
            top_in = byte_mode ? a_v[HALF_W-1] : a_v[DATA_W-1];
        shr = a_v >> 1;
        if (byte_mode) shr[HALF_W-1] = top_in;
        else           shr[DATA_W-1] = top_in;
    end

    function automatic logic dual_fill_is_carry(input logic [2:0] code);
        return single_op_e'(code) == S_RRC;
    endfunction

    // Pick the result and write-enable per opcode.
    always_comb begin
        res      = '0;
        wr       = 1'b0;
        eff_byte = 1'b0;
        unique case (single_op_e'(op))
            S_RRC, S_RRA: begin res = shr; wr = 1'b1; eff_byte = byte_mode; end
            S_SWPB:       begin res = {opnd[HALF_W-1:0], opnd[DATA_W-1:HALF_W]}; wr = 1'b1; end
            S_SXT:        begin res = {{(DATA_W-HALF_W){opnd[HALF_W-1]}}, opnd[HALF_W-1:0]}; wr = 1'b1; end
            default:      begin res = '0; end
        endcase
    end

    alu16_flag_eval #(.DATA_W(DATA_W)) u_feval (
        .val       (res),
        .byte_mode (eff_byte),
        .zero      (z_w),
        .neg       (n_w)
    );

    // Set the flags per opcode; unsupported codes and the swap keep them.
    always_comb begin
        unique case (single_op_e'(op))
            S_RRC, S_RRA: flags_out = '{v: 1'b0, n: n_w, z: z_w, c: a_v[0]};
            S_SXT:        flags_out = '{v: 1'b0, n: n_w, z: z_w, c: !z_w};
            default:      flags_out = flags_in;
        endcase
    end
endmodule

// File: rtl/alu16_exec.sv
`timescale 1ns/1ps
// Module: alu16_exec (top)
// Selects between the two instruction groups and registers result,
// write-enable and flags, giving a fixed latency of one clock.
// Assumes the requester holds no expectation of output when in_valid is low.
module alu16_exec
    import alu16_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_group,
    input  logic [3:0]        in_op2,
    input  logic [2:0]        in_op1,
    input  logic              in_byte,
    input  logic [DATA_W-1:0] in_src,
    input  logic [DATA_W-1:0] in_dst,
    input  logic [3:0]        in_flags,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_result,
    output logic              out_wr,
    output logic [3:0]        out_flags
);
    logic [DATA_W-1:0] d_res, s_res, nxt_res;
    logic              d_wr, s_wr, nxt_wr;
    flags_t            d_fl, s_fl, nxt_fl;

    alu16_dual #(.DATA_W(DATA_W)) u_dual (
        .op        (in_op2),
        .byte_mode (in_byte),
        .src       (in_src),
        .dst       (in_dst),
        .flags_in  (flags_t'(in_flags)),
        .res       (d_res),
        .wr        (d_wr),
        .flags_out (d_fl)
    );

    alu16_single #(.DATA_W(DATA_W)) u_single (
        .op        (in_op1),
        .byte_mode (in_byte),
        .opnd      (in_dst),
        .flags_in  (flags_t'(in_flags)),
        .res       (s_res),
        .wr        (s_wr),
        .flags_out (s_fl)
    );

    // Steer the selected group's outputs toward the output register.
    always_comb begin
        nxt_res = in_group ? s_res : d_res;
        nxt_wr  = in_group ? s_wr  : d_wr;
        nxt_fl  = in_group ? s_fl  : d_fl;
    end

    // Output register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_wr     <= 1'b0;
            out_result <= '0;
            out_flags  <= '0;
        end else begin
            out_valid <= in_valid;
            out_wr    <= in_valid && nxt_wr;
            if (in_valid) begin
                out_result <= nxt_res;
                out_flags  <= nxt_fl;
            end
        end
    end
endmodule

// File: rtl/alu16_exec_chk.sv
`timescale 1ns/1ps
// Module: alu16_exec_chk
// Temporal properties of the execute ALU, observed at its ports.
// Assumes the bind below attaches it to every alu16_exec instance.
module alu16_exec_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_group,
    input logic [3:0]        in_op2,
    input logic [2:0]        in_op1,
    input logic              in_byte,
    input logic [3:0]        in_flags,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_result,
    input logic              out_wr,
    input logic [3:0]        out_flags
);
    localparam int HALF_W = DATA_W / 2;

    assert_wr_needs_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_wr |-> out_valid);

    assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_idle_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_group && (in_op2 == 4'd9 || in_op2 == 4'd11)) |=> (out_valid && !out_wr));

    assert_logic_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_group && (in_op2 == 4'd11 || in_op2 == 4'd14 || in_op2 == 4'd15))
        |=> (out_flags[0] != out_flags[1]));

    assert_quiet_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_group && (in_op2 == 4'd4 || in_op2 == 4'd12 || in_op2 == 4'd13))
        |=> (out_wr && out_flags == $past(in_flags)));

    assert_byte_high_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_byte && (!in_group || in_op1 == 3'd0 || in_op1 == 3'd2))
        |=> (out_result[DATA_W-1:HALF_W] == '0));

    assert_shift_v_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_group && (in_op1 == 3'd0 || in_op1 == 3'd2)) |=> !out_flags[3]);

    assert_swap_flags_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_group && in_op1 == 3'd1) |=> (out_flags == $past(in_flags)));

    assert_noop_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ((!in_group && (in_op2 == 4'd10 || in_op2 < 4'd4)) || (in_group && in_op1[2])))
        |=> (!out_wr && out_flags == $past(in_flags)));
endmodule

bind alu16_exec alu16_exec_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_group   (in_group),
    .in_op2     (in_op2),
    .in_op1     (in_op1),
    .in_byte    (in_byte),
    .in_flags   (in_flags),
    .out_valid  (out_valid),
    .out_result (out_result),
    .out_wr     (out_wr),
    .out_flags  (out_flags)
);

// File: tb/alu16_exec_tb.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module alu16_exec_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_group = 1'b0;
    logic [3:0]  in_op2 = '0;
    logic [2:0]  in_op1 = '0;
    logic        in_byte = 1'b0;
    logic [15:0] in_src = '0;
    logic [15:0] in_dst = '0;
    logic [3:0]  in_flags = '0;
    logic        out_valid;
    logic [15:0] out_result;
    logic        out_wr;
    logic [3:0]  out_flags;

    int n_checks = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    alu16_exec u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_group(in_group),
        .in_op2(in_op2), .in_op1(in_op1), .in_byte(in_byte), .in_src(in_src),
        .in_dst(in_dst), .in_flags(in_flags), .out_valid(out_valid),
        .out_result(out_result), .out_wr(out_wr), .out_flags(out_flags)
    );

    task automatic check(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Drive one request on a falling edge, check it on the next falling edge.
    task automatic run_op(input string tag, input logic grp, input logic [3:0] op2,
                          input logic [2:0] op1, input logic byt,
                          input logic [15:0] src, input logic [15:0] dst,
                          input logic [3:0] fl, input logic exp_wr, input logic chk_res,
                          input logic [15:0] exp_res, input logic [3:0] exp_fl);
        @(negedge clk);
        in_valid = 1'b1; in_group = grp; in_op2 = op2; in_op1 = op1;
        in_byte = byt; in_src = src; in_dst = dst; in_flags = fl;
        @(negedge clk);
        in_valid = 1'b0;
        check(tag, "valid", {15'd0, out_valid}, 16'd1);
        check(tag, "wr", {15'd0, out_wr}, {15'd0, exp_wr});
        check(tag, "flags", {12'd0, out_flags}, {12'd0, exp_fl});
        if (chk_res) check(tag, "result", out_result, exp_res);
    endtask

    task automatic t_reset();
        check("R1", "reset valid", {15'd0, out_valid}, 16'd0);
        check("R1", "reset wr", {15'd0, out_wr}, 16'd0);
        check("R1", "reset flags", {12'd0, out_flags}, 16'd0);
        check("R1", "reset result", out_result, 16'd0);
    endtask

    task automatic t_idle();
        @(negedge clk);
        in_valid = 1'b0; in_group = 1'b0; in_op2 = 4'd4;
        @(negedge clk);
        check("R1", "idle valid", {15'd0, out_valid}, 16'd0);
        check("R1", "idle wr", {15'd0, out_wr}, 16'd0);
    endtask

    task automatic t_add();
        run_op("R2", 0, 4'd5, 0, 0, 16'h0001, 16'h7FFF, 4'h0, 1, 1, 16'h8000, 4'b1100);
        run_op("R2", 0, 4'd5, 0, 0, 16'h0001, 16'hFFFF, 4'h0, 1, 1, 16'h0000, 4'b0011);
        run_op("R2", 0, 4'd5, 0, 0, 16'h8000, 16'h8000, 4'h0, 1, 1, 16'h0000, 4'b1011);
    endtask

    task automatic t_addc();
        run_op("R3", 0, 4'd6, 0, 0, 16'h0002, 16'h0001, 4'b0001, 1, 1, 16'h0004, 4'b0000);
        run_op("R3", 0, 4'd6, 0, 0, 16'h0002, 16'h0001, 4'b0000, 1, 1, 16'h0003, 4'b0000);
    endtask

    task automatic t_sub();
        run_op("R4", 0, 4'd8, 0, 0, 16'h0005, 16'h0005, 4'h0, 1, 1, 16'h0000, 4'b0011);
        run_op("R4", 0, 4'd8, 0, 0, 16'h0005, 16'h0003, 4'h0, 1, 1, 16'hFFFE, 4'b0100);
        run_op("R4", 0, 4'd8, 0, 0, 16'h0001, 16'h8000, 4'h0, 1, 1, 16'h7FFF, 4'b1001);
        run_op("R4", 0, 4'd7, 0, 0, 16'h0003, 16'h0005, 4'b0000, 1, 1, 16'h0001, 4'b0001);
        run_op("R4", 0, 4'd7, 0, 0, 16'h0003, 16'h0005, 4'b0001, 1, 1, 16'h0002, 4'b0001);
    endtask

    task automatic t_cmp_bit();
        run_op("R5", 0, 4'd9, 0, 0, 16'h0003, 16'h0003, 4'h0, 0, 0, 16'h0, 4'b0011);
        run_op("R5", 0, 4'd9, 0, 0, 16'h0004, 16'h0003, 4'h0, 0, 0, 16'h0, 4'b0100);
        run_op("R5", 0, 4'd11, 0, 0, 16'h8001, 16'h8000, 4'h0, 0, 0, 16'h0, 4'b0101);
    endtask

    task automatic t_logic();
        run_op("R6", 0, 4'd15, 0, 0, 16'h0FF0, 16'hF0F0, 4'b1000, 1, 1, 16'h00F0, 4'b0001);
        run_op("R6", 0, 4'd15, 0, 0, 16'hFF00, 16'h00FF, 4'h0, 1, 1, 16'h0000, 4'b0010);
        run_op("R6", 0, 4'd14, 0, 0, 16'h8000, 16'h8001, 4'h0, 1, 1, 16'h0001, 4'b1001);
        run_op("R6", 0, 4'd14, 0, 0, 16'h0F00, 16'h8000, 4'h0, 1, 1, 16'h8F00, 4'b0101);
    endtask

    task automatic t_quiet();
        run_op("R7", 0, 4'd4, 0, 0, 16'h1234, 16'hFFFF, 4'b1010, 1, 1, 16'h1234, 4'b1010);
        run_op("R7", 0, 4'd12, 0, 0, 16'h00F0, 16'hFFFF, 4'b0101, 1, 1, 16'hFF0F, 4'b0101);
        run_op("R7", 0, 4'd13, 0, 0, 16'h0034, 16'h1200, 4'b0000, 1, 1, 16'h1234, 4'b0000);
    endtask

    task automatic t_byte();
        run_op("R8", 0, 4'd5, 0, 1, 16'h3401, 16'h12FF, 4'h0, 1, 1, 16'h0000, 4'b0011);
        run_op("R8", 0, 4'd5, 0, 1, 16'h0001, 16'h007F, 4'h0, 1, 1, 16'h0080, 4'b1100);
        run_op("R8", 0, 4'd4, 0, 1, 16'hABCD, 16'h0000, 4'b0010, 1, 1, 16'h00CD, 4'b0010);
        run_op("R8", 0, 4'd8, 0, 1, 16'h0001, 16'hFF00, 4'h0, 1, 1, 16'h00FF, 4'b0100);
    endtask

    task automatic t_rrc();
        run_op("R9", 1, 0, 3'd0, 0, 16'h0, 16'h0003, 4'b1001, 1, 1, 16'h8001, 4'b0101);
        run_op("R9", 1, 0, 3'd0, 1, 16'h0, 16'hFF02, 4'b0000, 1, 1, 16'h0001, 4'b0000);
    endtask

    task automatic t_rra();
        run_op("R10", 1, 0, 3'd2, 0, 16'h0, 16'h8002, 4'b1000, 1, 1, 16'hC001, 4'b0100);
        run_op("R10", 1, 0, 3'd2, 0, 16'h0, 16'h0001, 4'b0000, 1, 1, 16'h0000, 4'b0011);
        run_op("R10", 1, 0, 3'd2, 1, 16'h0, 16'h1281, 4'b0000, 1, 1, 16'h00C0, 4'b0101);
    endtask

    task automatic t_swpb();
        run_op("R11", 1, 0, 3'd1, 0, 16'h0, 16'h12AB, 4'b1111, 1, 1, 16'hAB12, 4'b1111);
        run_op("R11", 1, 0, 3'd1, 1, 16'h0, 16'h12AB, 4'b0000, 1, 1, 16'hAB12, 4'b0000);
    endtask

    task automatic t_sxt();
        run_op("R12", 1, 0, 3'd3, 0, 16'h0, 16'h0080, 4'b1000, 1, 1, 16'hFF80, 4'b0101);
        run_op("R12", 1, 0, 3'd3, 0, 16'h0, 16'hFF00, 4'b0000, 1, 1, 16'h0000, 4'b0010);
        run_op("R12", 1, 0, 3'd3, 1, 16'h0, 16'h1234, 4'b0000, 1, 1, 16'h0034, 4'b0001);
    endtask

    task automatic t_noop();
        run_op("R13", 0, 4'd10, 0, 0, 16'h1111, 16'h2222, 4'b0101, 0, 0, 16'h0, 4'b0101);
        run_op("R13", 0, 4'd2, 0, 0, 16'h1111, 16'h2222, 4'b1010, 0, 0, 16'h0, 4'b1010);
        run_op("R13", 1, 0, 3'd5, 0, 16'h1111, 16'h2222, 4'b0110, 0, 0, 16'h0, 4'b0110);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_idle();
        t_add();
        t_addc();
        t_sub();
        t_cmp_bit();
        t_logic();
        t_quiet();
        t_byte();
        t_rrc();
        t_rra();
        t_swpb();
        t_sxt();
        t_noop();
        t_idle();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end
endmodule